// File: doc/BRIEF.md
# Clock-Rate Enable Generator

This block paces the CPU and six peripherals from one oscillator clock. It gives out single-cycle enable strobes and no derived clocks. The CPU strobe marks one machine cycle. Each peripheral strobe marks one peripheral cycle, for the watchdog, the counter array, the serial port (shift and fixed-rate modes), Timer2, Timer1 and Timer0. Every consumer runs on the oscillator clock and advances only when its strobe is high.

An 8-bit control register sets the rates. Bit 0 is the double-speed switch. When it is clear, every strobe fires once per 12 oscillator clocks. When it is set, the CPU strobe fires once per 6 clocks. Each peripheral bit (bits 1 to 6) then keeps its own peripheral at 6 clocks when clear, or holds it at 12 clocks when set. A single free-running modulo-12 phase counter drives every strobe, so the two rates always stay aligned.

A change of rate waits for the next wrap of the phase counter. Because of this, no cycle is ever cut short. Software reads and writes the register through one select line.

Top module: `clk_rate_gen`

## Requirements
- R1: After reset the register reads 0x00, and the phase counter starts at 0. The first CPU and peripheral strobes come on the 12th rising edge after reset release, and all channels run at 12 clocks per cycle.
- R2: A clock edge with sel_i and we_i both high loads wdata_i into the register. rdata_o always shows the register with bit 7 forced to 0. An edge where sel_i or we_i is low leaves the register unchanged.
- R3: While the active value of bit 0 is 0, cpu_stb_o and all six per_stb_o bits pulse only at phase 11, once every 12 clocks, whatever bits 6..1 hold.
- R4: While the active value of bit 0 is 1, cpu_stb_o pulses at phases 5 and 11, once every 6 clocks.
- R5: While the active value of bit 0 is 1, per_stb_o[k] uses register bit k+1: 0 gives pulses at phases 5 and 11, and 1 gives pulses only at phase 11. The mapping is per_stb_o[0]=Timer0 (bit 1), [1]=Timer1 (bit 2), [2]=Timer2 (bit 3), [3]=serial (bit 4), [4]=counter array (bit 5), [5]=watchdog (bit 6). A peripheral strobe never fires without a CPU strobe in the same cycle.
- R6: Every strobe is one clock wide. Every 12-clock strobe lines up with a 6-clock strobe at phase 11.
- R7: The register value is copied into each channel's active rate only at phase 11, and the new rate applies from phase 0. Two consecutive pulses of one channel are never fewer than 6 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable, qualified by sel_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register contents, bit 7 always 0 |
| cpu_stb_o | output | 1 | Machine-cycle enable strobe |
| per_stb_o | output | 6 | Peripheral enable strobes, Timer0 at index 0 up to watchdog at index 5 |

## Verification
The assertions take for granted that sel_i, we_i and wdata_i are steady around each rising edge, and that a write can land on any phase, including phase 11 itself. The register checks also assume that nothing but the select/write pair changes the register. The stimulus changes inputs only just after the falling edge. It places writes at fixed phases and at random offsets, including the wrap cycle, and it includes writes with only one of sel_i or we_i high.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned N_PER    = 6;
  localparam int unsigned SLOW_CYC = 12;
  localparam int unsigned N_CH     = N_PER + 1;  // channel 0 = cpu

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/crg_ctl_reg.sv
module crg_ctl_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-2:0] ctl_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-2:0] ctl_q;  // top bit is reserved: not stored

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ctl_q <= '0;
    else if (sel_i && we_i) ctl_q <= wdata_i[DW-2:0];
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = {1'b0, ctl_q};

  AST_WR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i) |=> (rdata_o == {1'b0, $past(wdata_i[DW-2:0])})); // R2
  AST_NO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i) |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/crg_phase_ctr.sv
module crg_phase_ctr #(
  parameter int unsigned SLOW_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_tick_o,
  output logic slow_tick_o
);
  localparam int unsigned CW   = $clog2(SLOW_CYC);
  localparam int unsigned HALF = SLOW_CYC / 2;
  localparam logic [CW-1:0] LAST = CW'(SLOW_CYC - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign slow_tick_o = (cnt_q == LAST);
  assign fast_tick_o = (cnt_q == LAST) || (cnt_q == MID);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_o |=> (cnt_q == '0)); // R7
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_tick_o |=> !fast_tick_o); // R6
endmodule

// File: rtl/crg_rate_sel.sv
module crg_rate_sel
  import clk_rate_pkg::*;
#(
  parameter int unsigned CH = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CH-1:0] fast_req_i,
  input  logic          fast_tick_i,
  input  logic          slow_tick_i,
  output logic [CH-1:0] stb_o
);
  rate_e act_q [CH];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    // rate only moves on the shared wrap, so no cycle is cut short
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          act_q[c] <= RATE_SLOW;
      else if (slow_tick_i) act_q[c] <= fast_req_i[c] ? RATE_FAST : RATE_SLOW;
    end

    assign stb_o[c] = (act_q[c] == RATE_FAST) ? fast_tick_i : slow_tick_i;

    AST_RATE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_q[c]) |-> $past(slow_tick_i)); // R7
    AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o[c] |=> !stb_o[c]); // R6
  end
endmodule

// File: rtl/clk_rate_gen.sv
module clk_rate_gen
  import clk_rate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] rdata_o,
  output logic             cpu_stb_o,
  output logic [N_PER-1:0] per_stb_o
);
  logic [CTL_W-2:0] ctl;
  logic             fast_tick, slow_tick;
  logic [N_CH-1:0]  fast_req, stb;
  logic             dbl;

  crg_ctl_reg #(.DW(CTL_W)) u_reg (
    .clk_i, .rst_ni, .sel_i, .we_i, .wdata_i,
    .ctl_o(ctl), .rdata_o
  );

  crg_phase_ctr #(.SLOW_CYC(SLOW_CYC)) u_ctr (
    .clk_i, .rst_ni, .fast_tick_o(fast_tick), .slow_tick_o(slow_tick)
  );

  assign dbl         = ctl[0];
  assign fast_req[0] = dbl;
  for (genvar p = 0; p < N_PER; p++) begin : g_req
    // peripheral bit set = stay slow; only meaningful in double speed
    assign fast_req[p+1] = dbl & ~ctl[p+1];
  end

  crg_rate_sel #(.CH(N_CH)) u_sel (
    .clk_i, .rst_ni, .fast_req_i(fast_req),
    .fast_tick_i(fast_tick), .slow_tick_i(slow_tick), .stb_o(stb)
  );

  assign cpu_stb_o = stb[0];
  assign per_stb_o = stb[N_CH-1:1];

  AST_PER_NEEDS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|per_stb_o) |-> cpu_stb_o); // R5
  AST_RSVD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[CTL_W-1]); // R2
  AST_SLOW_WHEN_STD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_tick && !dbl) |=> !cpu_stb_o); // R3
endmodule

// File: tb/clk_rate_gen_test.sv
`timescale 1ns/1ps
module clk_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cpu_stb;
  logic [5:0] per_stb;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  clk_rate_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .cpu_stb_o(cpu_stb), .per_stb_o(per_stb)
  );

  typedef struct packed {
    logic [7:0] rd;
    logic [6:0] stb;
    logic       x2;
  } exp_t;

  exp_t q[$];
  int   m_cnt = 0;
  logic [6:0] m_act = '0;
  logic [7:0] m_reg = '0;

  // reference model: pushes the expected outputs for the cycle after each edge
  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (m_cnt == 11) begin
        m_act[0] = m_reg[0];
        for (int i = 1; i < 7; i++) m_act[i] = m_reg[0] & ~m_reg[i];
      end
      m_cnt = (m_cnt == 11) ? 0 : m_cnt + 1;
      if (sel && we) m_reg = {1'b0, wdata[6:0]};
      e.rd = m_reg;
      for (int c = 0; c < 7; c++)
        e.stb[c] = (m_cnt == 11) || (m_act[c] && m_cnt == 5);
      e.x2 = m_act[0];
      q.push_back(e);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  int cyc = 0;
  int last [7];
  logic [6:0] prev_stb = '0;
  initial for (int c = 0; c < 7; c++) last[c] = -100;

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [6:0] got;
      e = q.pop_front();
      got = {per_stb, cpu_stb};
      cyc++;
      chk("R2 rdata", rdata, e.rd);
      chk(cyc <= 12 ? "R1 cpu" : (e.x2 ? "R4 cpu" : "R3 cpu"), got[0], e.stb[0]);
      for (int c = 1; c < 7; c++)
        chk(cyc <= 12 ? "R1 per" : (e.x2 ? "R5 per" : "R3 per"), got[c], e.stb[c]);
      for (int c = 0; c < 7; c++) begin
        if (got[c]) begin
          chk("R6 pulse width", prev_stb[c], 0);
          if (last[c] >= 0) chk("R7 min gap", (cyc - last[c]) >= 6, 1);
          last[c] = cyc;
        end
      end
      prev_stb = got;
    end
  end

  task automatic wr(input logic [7:0] d, input logic s = 1'b1, input logic w = 1'b1);
    @(negedge clk); #1;
    sel = s; we = w; wdata = d;
    @(negedge clk); #1;
    sel = 1'b0; we = 1'b0; wdata = $urandom;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset cpu", cpu_stb, 0);
    chk("R1 reset per", per_stb, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(40);
    wr(8'h01);                 // double speed, all peripherals fast (R4 R5)
    idle(40);
    wr(8'hFF);                 // reserved bit written, peripherals held slow (R2 R5)
    idle(40);
    wr(8'h2B);                 // mixed peripheral rates (R5)
    idle(40);
    wr(8'h00, 1'b0, 1'b1);     // no select: ignored (R2)
    idle(30);
    wr(8'h00, 1'b1, 1'b0);     // no write enable: ignored (R2)
    idle(30);
    wr(8'h7E);                 // peripheral bits without double speed (R3)
    idle(40);
    wr(8'h55);
    idle(7);
    wr(8'h00);                 // rate drop mid-cycle (R7)
    idle(30);
    for (int k = 0; k < 60; k++) begin
      wr($urandom);
      idle($urandom_range(0, 25));
    end
    idle(30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule